// File: doc/BRIEF.md
# Two-Wire Channel Enable Register

This block is a slave on a two-wire serial bus (I2C) that holds a single channel-enable register for an eight-way bus switch. Each register bit drives one enable output, and these outputs would close external pass gates. The upstream clock and data lines are first brought into the system clock domain. They then pass a glitch filter and an event detector, which finds START, STOP and both clock edges. A state machine turns those events into address matching, acknowledges, data reception and read-back.

The slave answers to one 7-bit address. Its upper four bits are fixed at binary 1110, and three strap inputs supply the lower three. The protocol carries no command or sub-address byte: every data byte written goes to the register, and a read returns the register directly. A newly written value is parked in a shadow register. It reaches the enable outputs only when a STOP is seen, so that downstream lines are connected only while the bus is idle.

The state machine has these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WR_BYTE`, `ST_WR_ACK`, `ST_RD_BYTE`, `ST_RD_ACK` and `ST_SKIP`. A STOP from any state goes to `ST_IDLE`. A START from any state goes to `ST_ADDR`. All other transitions happen on a falling clock edge:

- From `ST_ADDR` after the eighth bit: on an address match to `ST_ADDR_ACK`, otherwise to `ST_SKIP`.
- From `ST_ADDR_ACK`: to `ST_RD_BYTE` when the R/W bit is 1, to `ST_WR_BYTE` when it is 0.
- From `ST_WR_BYTE` after eight bits: to `ST_WR_ACK`.
- From `ST_WR_ACK`: back to `ST_WR_BYTE`.
- From `ST_RD_BYTE` after eight bits: to `ST_RD_ACK`.
- From `ST_RD_ACK`: to `ST_RD_BYTE` if the master acknowledged, otherwise to `ST_SKIP`.

Top module: `i2c_chansel`

## Requirements
- R1: The slave pulls SDA low during the ninth clock of the address byte only when the first seven bits equal {1110, strap[2], strap[1], strap[0]}, sent most significant bit first.
- R2: The eighth address bit selects the direction, where 1 means read and 0 means write.
- R3: In a write, every data byte is acknowledged with SDA low in its ninth clock. When several bytes arrive before STOP, only the last one is kept.
- R4: chan_en changes only in the cycle after a STOP is detected, and then takes the last written byte. Bit n of the byte drives chan_en[n], and any combination of bits is allowed.
- R5: A read returns the value currently on chan_en, most significant bit first. The slave keeps sending bytes while the master acknowledges, and after a NACK it leaves SDA released until the next START or STOP.
- R6: After a non-matching address, the slave leaves SDA released and ignores data bytes until the next START.
- R7: A repeated START restarts address matching. A value written before a repeated START still waits for the next STOP, and a read in between returns the old applied value.
- R8: While rst_n is low, chan_en is 0, SDA is released, any pending write is discarded and the state machine is idle. Coming out of reset, all channels are deselected.
- R9: Pulses on SCL or SDA shorter than FILT_LEN system clock cycles are ignored. They create no clock edge, no START and no STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least about 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Upstream serial clock line |
| sda_in | input | 1 | Upstream serial data line, read back as the wired bus value |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA (1 drives the line low) |
| strap | input | 3 | Strap bits forming the low three address bits |
| chan_en | output | NCH | Channel enable outputs, bit n enables channel n |

## Verification
The bench sweeps all eight strap settings against all eight candidate addresses. A design with a wrong address compare would acknowledge the wrong slot or miss its own. The bench also checks the outputs after the last data bit but before STOP, where an eager design would already have switched channels. Multi-byte writes, a repeated START from a pending write into a read, and a repeated START after a foreign address check that the last byte wins and that the shadow waits for the real STOP. Two-cycle pulses are placed on both lines in every bit. An unfiltered design would then count extra bits or see false STARTs and STOPs, and would corrupt or drop the byte. A reset in the middle of a write checks that the pending value is discarded and not applied at the later STOP.

// File: rtl/i2csel_pkg.sv
package i2csel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } sel_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2csel_filter.sv
module i2csel_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == out_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                out_q <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign dout = out_q;

    // R9: the filtered level only moves to a value the synchroniser held
    p_filt_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> $past(sync_q[1]) == out_q);

endmodule

// File: rtl/i2csel_events.sv
module i2csel_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev,
    output logic fall_ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
    assign rise_ev  = scl_f & ~scl_p;
    assign fall_ev  = ~scl_f & scl_p;

endmodule

// File: rtl/i2csel_ctrl.sv
module i2csel_ctrl
    import i2csel_pkg::*;
#(
    parameter int          NCH     = 8,
    parameter logic [3:0]  ADDR_HI = 4'b1110
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_ev,
    input  logic           stop_ev,
    input  logic           rise_ev,
    input  logic           fall_ev,
    input  logic           sda_f,
    input  logic [2:0]     strap,
    output logic           sda_pull,
    output logic [NCH-1:0] chan_en
);
    localparam int         CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    sel_state_e          state_q, state_n;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   shift_q;
    logic [BYTE_W-1:0]   tx_q;
    logic [BYTE_W-1:0]   en_byte;
    logic [NCH-1:0]      shadow_q;
    logic [NCH-1:0]      en_q;
    logic                pend_q;
    logic                rw_q;
    logic                mack_q;
    logic                addr_hit;
    logic                counting;

    assign addr_hit = (shift_q[BYTE_W-1:1] == {ADDR_HI, strap});
    assign counting = (state_q != ST_IDLE) && (state_q != ST_SKIP);

    always_comb begin
        en_byte = '0;
        en_byte[NCH-1:0] = en_q;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (stop_ev) begin
            state_n = ST_IDLE;
        end else if (start_ev) begin
            state_n = ST_ADDR;
        end else if (fall_ev) begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_n = state_q;
                ST_ADDR:     if (bit_cnt == LAST_BIT) state_n = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: state_n = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (bit_cnt == LAST_BIT) state_n = ST_WR_ACK;
                ST_WR_ACK:   state_n = ST_WR_BYTE;
                ST_RD_BYTE:  if (bit_cnt == LAST_BIT) state_n = ST_RD_ACK;
                ST_RD_ACK:   state_n = mack_q ? ST_RD_BYTE : ST_SKIP;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bit_cnt  <= '0;
            shift_q  <= '0;
            tx_q     <= '0;
            shadow_q <= '0;
            en_q     <= '0;
            pend_q   <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (start_ev || stop_ev || (fall_ev && state_n != state_q))
                bit_cnt <= '0;
            else if (rise_ev && counting)
                bit_cnt <= bit_cnt + 1'b1;
            if (rise_ev)
                shift_q <= {shift_q[BYTE_W-2:0], sda_f};
            if (rise_ev && state_q == ST_RD_ACK)
                mack_q <= ~sda_f;
            if (state_q == ST_ADDR && state_n == ST_ADDR_ACK)
                rw_q <= shift_q[0];
            if (state_q == ST_WR_BYTE && state_n == ST_WR_ACK) begin
                shadow_q <= shift_q[NCH-1:0];
                pend_q   <= 1'b1;
            end
            if (fall_ev && state_n == ST_RD_BYTE && state_q != ST_RD_BYTE)
                tx_q <= en_byte;
            else if (fall_ev && state_q == ST_RD_BYTE)
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            if (stop_ev && pend_q) begin
                en_q   <= shadow_q;
                pend_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_BYTE:             sda_pull = ~tx_q[BYTE_W-1];
            default:                sda_pull = 1'b0;
        endcase
    end

    assign chan_en = en_q;

    // R4: enables move only right after a STOP
    p_en_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> $past(stop_ev));

    // R3: a STOP always consumes the pending byte
    p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !pend_q);

    // R6: a skipped transfer never touches SDA
    p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SKIP |-> !sda_pull);

    // R7: START restarts address matching from bit zero
    p_start_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (state_q == ST_ADDR && bit_cnt == '0));

    // R1: the bit counter never passes one byte plus nothing
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_BIT);

endmodule

// File: rtl/i2c_chansel.sv
module i2c_chansel #(
    parameter int         NCH      = 8,
    parameter int         FILT_LEN = 4,
    parameter logic [3:0] ADDR_HI  = 4'b1110
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_in,
    input  logic           sda_in,
    output logic           sda_pull,
    input  logic [2:0]     strap,
    output logic [NCH-1:0] chan_en
);
    logic scl_f, sda_f;
    logic start_ev, stop_ev, rise_ev, fall_ev;

    i2csel_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_f));

    i2csel_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_f));

    i2csel_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .rise_ev(rise_ev), .fall_ev(fall_ev));

    i2csel_ctrl #(.NCH(NCH), .ADDR_HI(ADDR_HI)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .rise_ev(rise_ev), .fall_ev(fall_ev),
        .sda_f(sda_f), .strap(strap),
        .sda_pull(sda_pull), .chan_en(chan_en));

endmodule

// File: tb/i2c_chansel_tb.sv
module i2c_chansel_tb;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic       sda_pull;
    logic [7:0] chan_en;
    logic       sda_bus;
    int         n_chk = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    i2c_chansel u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull(sda_pull), .strap(strap), .chan_en(chan_en));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
        tick(Q);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        seen = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(~give_ack, s);
    endtask

    // every bit carries a 2-cycle SCL pulse while low and a 2-cycle SDA pulse while high
    task automatic send_byte_glitchy(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(4);
            scl_m = 1'b1; tick(2);
            scl_m = 1'b0; tick(Q - 6);
            scl_m = 1'b1; tick(4);
            sda_m = ~b[i]; tick(2);
            sda_m = b[i];  tick(2 * Q - 6);
            scl_m = 1'b0; tick(Q);
        end
        bit_io(1'b1, s);
        acked = ~s;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        logic [7:0] cur;
        logic [7:0] dat;
        cur = 8'h00;

        tick(5);
        check("R8 reset enables", chan_en, 8'h00);
        check("R8 reset sda released", sda_pull, 1'b0);
        rst_n = 1'b1;
        tick(5);

        // R1 R2 R4 R6: every strap against every address slot
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                strap = 3'(s);
                tick(2);
                dat = 8'((a * 37 + s * 11 + 1) & 255);
                bus_start();
                send_byte({4'b1110, 3'(a), 1'b0}, ack);
                check("R1 address ack", ack, (a == s));
                send_byte(dat, ack);
                if (a == s) check("R3 data ack", ack, 1'b1);
                else        check("R6 data ignored", ack, 1'b0);
                check("R4 held before stop", chan_en, cur);
                if (a == s) cur = dat;
                bus_stop();
                check("R4 applied at stop", chan_en, cur);
            end
        end

        strap = 3'd5;
        tick(2);

        // R3: last byte wins
        bus_start();
        send_byte(8'hEA, ack);
        check("R3 addr ack", ack, 1'b1);
        send_byte(8'h11, ack);
        check("R3 ack1", ack, 1'b1);
        send_byte(8'h22, ack);
        check("R3 ack2", ack, 1'b1);
        send_byte(8'hC3, ack);
        check("R3 ack3", ack, 1'b1);
        bus_stop();
        check("R3 last byte kept", chan_en, 8'hC3);

        // R5 R2: read back, ack then nack
        bus_start();
        send_byte(8'hEB, ack);
        check("R2 read addr ack", ack, 1'b1);
        recv_byte(1'b1, rd);
        check("R5 read byte1", rd, 8'hC3);
        recv_byte(1'b0, rd);
        check("R5 read byte2", rd, 8'hC3);
        check("R5 released after nack", sda_pull, 1'b0);
        bus_stop();
        check("R5 read leaves enables", chan_en, 8'hC3);

        // R7: pending write, repeated start, read
        bus_start();
        send_byte(8'hEA, ack);
        send_byte(8'h5A, ack);
        check("R7 write ack", ack, 1'b1);
        bus_start();
        send_byte(8'hEB, ack);
        check("R7 restart addr ack", ack, 1'b1);
        recv_byte(1'b0, rd);
        check("R7 read old value", rd, 8'hC3);
        check("R7 not applied yet", chan_en, 8'hC3);
        bus_stop();
        check("R7 applied at stop", chan_en, 8'h5A);

        // R7 R6: foreign address then repeated start to own
        bus_start();
        send_byte(8'hE4, ack);
        check("R6 foreign nack", ack, 1'b0);
        bus_start();
        send_byte(8'hEA, ack);
        check("R7 own after foreign", ack, 1'b1);
        send_byte(8'h0F, ack);
        bus_stop();
        check("R7 write after restart", chan_en, 8'h0F);

        // R9: glitches on both lines
        bus_start();
        send_byte(8'hEA, ack);
        send_byte_glitchy(8'hA5, ack);
        check("R9 glitchy byte ack", ack, 1'b1);
        bus_stop();
        check("R9 glitchy byte value", chan_en, 8'hA5);

        // R8: reset mid-write discards pending value
        bus_start();
        send_byte(8'hEA, ack);
        send_byte(8'h3C, ack);
        rst_n = 1'b0;
        tick(3);
        check("R8 reset clears enables", chan_en, 8'h00);
        check("R8 reset releases sda", sda_pull, 1'b0);
        rst_n = 1'b1;
        tick(3);
        bus_stop();
        check("R8 pending discarded", chan_en, 8'h00);

        bus_start();
        send_byte(8'hEA, ack);
        send_byte(8'h81, ack);
        bus_stop();
        check("R4 alive after reset", chan_en, 8'h81);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule